// File: doc/BRIEF.md
# Zero-Suppressed Strip Hit Encoder

This block is the digital back end of a 128-channel strip readout chip. Once per beam clock a strobe presents one 3-bit digitized amplitude for every channel. Channels whose amplitude does not exceed a programmable threshold, and channels that configuration has masked, are discarded. Each remaining channel becomes a 16-bit hit word. The word holds the amplitude, the 7-bit strip address and the value of a 6-bit beam-crossing counter.

Hit words wait in a small queue. They are then pushed out, with no trigger, over two serial lines that run in lockstep 16-bit frames. The frames on line 1 start half a frame after those on line 0. Hits go out in turn on line 0, then line 1, then line 0 again. A line with nothing to send carries an idle word whose amplitude field is zero, so it can never be mistaken for a hit.

Within one beam clock, a single-cycle find-first scanner moves the surviving channels into the queue at one per clock, lowest strip first. Configuration writes set the threshold and set or clear single mask bits. The beam strobe must be at least 16 clocks apart.

Top module: `strip_hit_encoder`

## Requirements
- R1: After reset the threshold is 0, no channel is masked, the overflow flag is 0, the beam counter is 0, both lines carry only idle words, and the next hit goes to line 0.
- R2: A channel produces a hit only when its amplitude is strictly greater than the threshold; an amplitude equal to the threshold produces nothing.
- R3: A masked channel produces no hit whatever its amplitude, and clearing its mask bit restores it.
- R4: A hit word is 16 bits sent MSB first: bits 15..13 amplitude, bits 12..6 strip number, bits 5..0 beam counter. The frame marker of a line is high during exactly the clock that carries bit 15.
- R5: The beam counter value in a hit is the number of strobes since reset before the one that captured it, modulo 64 (it wraps from 63 to 0).
- R6: Hits captured by one strobe leave in ascending strip order.
- R7: Successive hits alternate between the lines, and the first hit after reset goes on line 0 (the k-th hit, counted from 0, goes on line k mod 2).
- R8: A line with no hit to send carries the idle word 0x1FFF (amplitude field 0).
- R9: Frames on line 0 start every 16 clocks; frames on line 1 start 8 clocks after those on line 0.
- R10: The queue holds 4 words. A hit that arrives while the queue is full is dropped, and the overflow flag is set and stays set until reset.
- R11: Four hits in one beam clock, or one hit in each of four beam clocks 16 clocks apart, are all delivered, and overflow stays 0.
- R12: A strobe that arrives while hits of the previous strobe are still unscanned discards those hits and sets the overflow flag. The hit selected in that same clock is still queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_strobe | input | 1 | One-clock pulse marking a beam clock; samples amp_bus |
| amp_bus | input | 384 | Channel amplitudes, channel c in bits 3c+2..3c |
| thr_we | input | 1 | Write enable for the threshold |
| thr_val | input | 3 | New threshold value |
| mask_we | input | 1 | Write enable for one mask bit |
| mask_idx | input | 7 | Channel whose mask bit is written |
| mask_val | input | 1 | Mask bit value, 1 suppresses the channel |
| ser_out | output | 2 | Serial data, one bit per line |
| ser_frame | output | 2 | Per-line marker, high on the first bit of a word |
| overflow | output | 1 | Sticky flag for lost hits |

## Verification
The bench decodes both serial lines and compares every hit with a scoreboard built from the threshold and mask model. It therefore catches an inclusive threshold compare, an ignored mask bit, strips out of order, a beam counter that saturates or does not wrap at 64, and a line pointer that starts on line 1 or does not toggle. Each of these shows up as a wrong word, a missing word or a word on the wrong line.

Three corner cases get their own tests: a strobe that arrives while one hit is still unscanned, a ten-hit burst into a four-word queue, and four hits spread over four tight beam clocks. They expose a scanner that keeps stale hits, a queue that overwrites entries instead of dropping them, and an overflow flag that is set wrongly, set too late or not sticky. Every idle frame is also checked, so a design that emits a malformed idle word, one that could be read as a hit, is reported.

// File: rtl/strip_enc_pkg.sv
package strip_enc_pkg;

    localparam int NUM_CH  = 128;
    localparam int AMP_W   = 3;
    localparam int STRIP_W = $clog2(NUM_CH);
    localparam int BC_W    = 6;
    localparam int WORD_W  = AMP_W + STRIP_W + BC_W;

    typedef struct packed {
        logic [AMP_W-1:0]   amp;
        logic [STRIP_W-1:0] strip;
        logic [BC_W-1:0]    bc;
    } hit_word_t;

    // amplitude field zero: never a legal hit
    localparam hit_word_t IDLE_WORD = hit_word_t'({AMP_W'(0), {(WORD_W-AMP_W){1'b1}}});

    function automatic logic channel_fires(input logic [AMP_W-1:0] amp,
                                           input logic [AMP_W-1:0] thr,
                                           input logic             masked);
        return !masked && (amp > thr);
    endfunction

    function automatic hit_word_t pack_hit(input logic [AMP_W-1:0]   amp,
                                           input logic [STRIP_W-1:0] strip,
                                           input logic [BC_W-1:0]    bc);
        hit_word_t w;
        w.amp   = amp;
        w.strip = strip;
        w.bc    = bc;
        return w;
    endfunction

endpackage

// File: rtl/strip_enc_cfg.sv
module strip_enc_cfg
    import strip_enc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               thr_we,
    input  logic [AMP_W-1:0]   thr_val,
    input  logic               mask_we,
    input  logic [STRIP_W-1:0] mask_idx,
    input  logic               mask_val,
    output logic [AMP_W-1:0]   thr_q,
    output logic [NUM_CH-1:0]  mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '0;
            mask_q <= '0;
        end else begin
            if (thr_we)
                thr_q <= thr_val;
            if (mask_we)
                mask_q[mask_idx] <= mask_val;
        end
    end

endmodule

// File: rtl/strip_enc_scan.sv
module strip_enc_scan
    import strip_enc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strobe,
    input  logic [NUM_CH*AMP_W-1:0]  amp_bus,
    input  logic [AMP_W-1:0]         thr,
    input  logic [NUM_CH-1:0]        mask,
    output logic                     hit_valid,
    output hit_word_t                hit_word,
    output logic                     lost,
    output logic [BC_W-1:0]          beam_cnt
);

    logic [NUM_CH-1:0]             fire;
    logic [NUM_CH-1:0]             flags_q;
    logic [NUM_CH-1:0]             sel_oh;
    logic [NUM_CH-1:0][AMP_W-1:0]  amp_q;
    logic [STRIP_W-1:0]            sel_idx;
    logic                          sel_any;
    logic [BC_W-1:0]               bc_q;
    logic [BC_W-1:0]               bc_cap;

    // per-channel zero suppression
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fire
        assign fire[ch] = channel_fires(amp_bus[ch*AMP_W +: AMP_W], thr, mask[ch]);
    end

    // lowest pending strip wins
    always_comb begin
        sel_any = 1'b0;
        sel_idx = '0;
        for (int i = NUM_CH-1; i >= 0; i--) begin
            if (flags_q[i]) begin
                sel_any = 1'b1;
                sel_idx = STRIP_W'(i);
            end
        end
    end

    assign sel_oh = sel_any ? (NUM_CH'(1) << sel_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            bc_q    <= '0;
            bc_cap  <= '0;
        end else if (strobe) begin
            flags_q <= fire;
            bc_cap  <= bc_q;
            bc_q    <= bc_q + BC_W'(1);
        end else begin
            flags_q <= flags_q & ~sel_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (strobe)
            amp_q <= amp_bus;
    end

    assign lost      = strobe && |(flags_q & ~sel_oh);
    assign hit_valid = sel_any;
    assign hit_word  = pack_hit(amp_q[sel_idx], sel_idx, bc_cap);
    assign beam_cnt  = bc_q;

endmodule

// File: rtl/strip_enc_fifo.sv
module strip_enc_fifo
    import strip_enc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH+1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  hit_word_t  din,
    input  logic       pop,
    output hit_word_t  dout,
    output logic       empty,
    output logic       drop,
    output logic [CW-1:0] count
);

    hit_word_t       mem [DEPTH];
    logic [AW-1:0]   wr_q;
    logic [AW-1:0]   rd_q;
    logic            full;
    logic            do_push;
    logic            do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
            if (do_pop)
                rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/strip_enc_ser.sv
module strip_enc_ser
    import strip_enc_pkg::*;
#(
    parameter int NUM_LINES = 2,
    localparam int OFF      = WORD_W / NUM_LINES,
    localparam int PH_W     = $clog2(WORD_W),
    localparam int PTR_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  q_empty,
    input  hit_word_t             q_word,
    output logic                  pop,
    output logic [NUM_LINES-1:0]  ser_out,
    output logic [NUM_LINES-1:0]  ser_frame,
    output logic [PTR_W-1:0]      line_ptr
);

    logic [PH_W-1:0]    phase_q;
    logic [NUM_LINES-1:0] load;
    hit_word_t          shreg [NUM_LINES];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign load[l]    = (phase_q == PH_W'(l*OFF));
        assign ser_out[l] = shreg[l][WORD_W-1];
    end

    always_comb begin
        pop = 1'b0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (load[l] && (line_ptr == PTR_W'(l)) && !q_empty)
                pop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            line_ptr <= '0;
        end else begin
            phase_q <= (phase_q == PH_W'(WORD_W-1)) ? '0 : phase_q + PH_W'(1);
            if (pop)
                line_ptr <= (line_ptr == PTR_W'(NUM_LINES-1)) ? '0 : line_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NUM_LINES; l++)
                shreg[l] <= IDLE_WORD;
            ser_frame <= '0;
        end else begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (load[l]) begin
                    shreg[l]     <= (pop && line_ptr == PTR_W'(l)) ? q_word : IDLE_WORD;
                    ser_frame[l] <= 1'b1;
                end else begin
                    shreg[l]     <= hit_word_t'({shreg[l][WORD_W-2:0], 1'b0});
                    ser_frame[l] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/strip_hit_encoder.sv
module strip_hit_encoder
    import strip_enc_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4,
    parameter int NUM_LINES   = 2,
    localparam int CNT_W      = $clog2(QUEUE_DEPTH+1),
    localparam int PTR_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     beam_strobe,
    input  logic [NUM_CH*AMP_W-1:0]  amp_bus,
    input  logic                     thr_we,
    input  logic [AMP_W-1:0]         thr_val,
    input  logic                     mask_we,
    input  logic [STRIP_W-1:0]       mask_idx,
    input  logic                     mask_val,
    output logic [NUM_LINES-1:0]     ser_out,
    output logic [NUM_LINES-1:0]     ser_frame,
    output logic                     overflow
);

    logic [AMP_W-1:0]   thr_q;
    logic [NUM_CH-1:0]  mask_q;
    logic               hit_valid;
    hit_word_t          hit_word;
    logic               scan_lost;
    logic [BC_W-1:0]    beam_cnt;
    hit_word_t          q_word;
    logic               q_empty;
    logic               q_drop;
    logic [CNT_W-1:0]   fifo_cnt;
    logic               ser_pop;
    logic [PTR_W-1:0]   line_ptr;

    strip_enc_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .thr_we   (thr_we),
        .thr_val  (thr_val),
        .mask_we  (mask_we),
        .mask_idx (mask_idx),
        .mask_val (mask_val),
        .thr_q    (thr_q),
        .mask_q   (mask_q)
    );

    strip_enc_scan u_scan (
        .clk       (clk),
        .rst       (rst),
        .strobe    (beam_strobe),
        .amp_bus   (amp_bus),
        .thr       (thr_q),
        .mask      (mask_q),
        .hit_valid (hit_valid),
        .hit_word  (hit_word),
        .lost      (scan_lost),
        .beam_cnt  (beam_cnt)
    );

    strip_enc_fifo #(.DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (hit_valid),
        .din   (hit_word),
        .pop   (ser_pop),
        .dout  (q_word),
        .empty (q_empty),
        .drop  (q_drop),
        .count (fifo_cnt)
    );

    strip_enc_ser #(.NUM_LINES(NUM_LINES)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .q_empty   (q_empty),
        .q_word    (q_word),
        .pop       (ser_pop),
        .ser_out   (ser_out),
        .ser_frame (ser_frame),
        .line_ptr  (line_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            overflow <= 1'b0;
        else if (scan_lost || q_drop)
            overflow <= 1'b1;
    end

endmodule

// File: rtl/strip_enc_chk.sv
module strip_enc_chk #(
    parameter int QDEPTH    = 4,
    parameter int CNT_W     = 3,
    parameter int PTR_W     = 1,
    parameter int WORD_W    = 16,
    parameter int NUM_LINES = 2,
    parameter int BC_W      = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 beam_strobe,
    input logic [BC_W-1:0]      beam_cnt,
    input logic [CNT_W-1:0]     fifo_cnt,
    input logic                 pop,
    input logic [PTR_W-1:0]     ptr,
    input logic [NUM_LINES-1:0] ser_frame,
    input logic                 overflow
);

    logic [7:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (ser_frame[0]) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q  <= gap_q + 8'd1;
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(QDEPTH));

    assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_beam_step_R5: assert property (@(posedge clk) disable iff (rst)
        beam_strobe |=> beam_cnt == $past(beam_cnt) + BC_W'(1));

    assert_beam_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !beam_strobe |=> $stable(beam_cnt));

    assert_line_turn_R7: assert property (@(posedge clk) disable iff (rst)
        pop |=> ptr != $past(ptr));

    assert_line_keep_R7: assert property (@(posedge clk) disable iff (rst)
        !pop |=> $stable(ptr));

    assert_frame_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ser_frame));

    assert_frame_period_R9: assert property (@(posedge clk) disable iff (rst)
        (ser_frame[0] && seen_q) |-> gap_q == 8'(WORD_W-1));

    assert_frame_offset_R9: assert property (@(posedge clk) disable iff (rst)
        (ser_frame[1] && seen_q) |-> gap_q == 8'(WORD_W/NUM_LINES-1));

endmodule

bind strip_hit_encoder strip_enc_chk #(
    .QDEPTH    (QUEUE_DEPTH),
    .CNT_W     (CNT_W),
    .PTR_W     (PTR_W),
    .WORD_W    (strip_enc_pkg::WORD_W),
    .NUM_LINES (NUM_LINES),
    .BC_W      (strip_enc_pkg::BC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .beam_strobe (beam_strobe),
    .beam_cnt    (beam_cnt),
    .fifo_cnt    (fifo_cnt),
    .pop         (ser_pop),
    .ptr         (line_ptr),
    .ser_frame   (ser_frame),
    .overflow    (overflow)
);

// File: tb/test_strip_hit_encoder.sv
`timescale 1ns/1ps
module test_strip_hit_encoder;

    localparam int NCH  = 128;
    localparam logic [15:0] IDLE = 16'h1FFF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         beam_strobe = 1'b0;
    logic [383:0] amp_bus = '0;
    logic         thr_we = 1'b0;
    logic [2:0]   thr_val = '0;
    logic         mask_we = 1'b0;
    logic [6:0]   mask_idx = '0;
    logic         mask_val = 1'b0;
    logic [1:0]   ser_out;
    logic [1:0]   ser_frame;
    logic         overflow;

    strip_hit_encoder i_strip_hit_encoder (
        .clk(clk), .rst(rst), .beam_strobe(beam_strobe), .amp_bus(amp_bus),
        .thr_we(thr_we), .thr_val(thr_val), .mask_we(mask_we),
        .mask_idx(mask_idx), .mask_val(mask_val),
        .ser_out(ser_out), .ser_frame(ser_frame), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int idle_cnt = 0;
    int idle_bad = 0;
    int rx_n = 0;
    bit loose = 1'b0;
    bit done = 1'b0;

    logic [2:0]  amps [NCH];
    logic [2:0]  thr_m = '0;
    logic [NCH-1:0] mask_m = '0;
    logic [5:0]  bc_m = '0;
    logic [15:0] exp_q [$];
    logic [15:0] rx_log [$];

    logic [15:0] sh [2];
    int          cnt [2];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            cnt[0] = 0; cnt[1] = 0; rx_n = 0;
        end else begin
            for (int l = 0; l < 2; l++) begin
                if (ser_frame[l]) begin
                    sh[l] = {15'd0, ser_out[l]};
                    cnt[l] = 1;
                end else if (cnt[l] > 0 && cnt[l] < 16) begin
                    sh[l] = {sh[l][14:0], ser_out[l]};
                    cnt[l] = cnt[l] + 1;
                end
                if (cnt[l] == 16) begin
                    cnt[l] = 0;
                    if (sh[l][15:13] == 3'd0) begin
                        idle_cnt++;
                        if (sh[l] != IDLE) begin
                            idle_bad++;
                            chk(1'b0, "R8 idle word", 32'(sh[l]), 32'(IDLE));
                        end
                    end else begin
                        chk(l == (rx_n % 2), "R7 line of hit", 32'(l), 32'(rx_n % 2));
                        rx_n++;
                        if (loose) rx_log.push_back(sh[l]);
                        else if (exp_q.size() == 0)
                            chk(1'b0, "R2/R3 unexpected hit", 32'(sh[l]), 32'h0);
                        else begin
                            logic [15:0] e;
                            e = exp_q.pop_front();
                            chk(sh[l] == e, "R4/R5/R6 hit word", 32'(sh[l]), 32'(e));
                        end
                    end
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        thr_m = '0; mask_m = '0; bc_m = '0;
        exp_q.delete(); rx_log.delete();
        for (int c = 0; c < NCH; c++) amps[c] = '0;
    endtask

    task automatic set_thr(input logic [2:0] v);
        thr_we = 1'b1; thr_val = v; thr_m = v;
        @(posedge clk); #1 thr_we = 1'b0;
    endtask

    task automatic set_mask(input int idx, input bit v);
        mask_we = 1'b1; mask_idx = 7'(idx); mask_val = v; mask_m[idx] = v;
        @(posedge clk); #1 mask_we = 1'b0;
    endtask

    task automatic clear_amps();
        for (int c = 0; c < NCH; c++) amps[c] = '0;
    endtask

    // driver: predicts hits and fires one strobe
    task automatic fire_beam(input int gap);
        for (int c = 0; c < NCH; c++) begin
            amp_bus[c*3 +: 3] = amps[c];
            if (!mask_m[c] && amps[c] > thr_m)
                exp_q.push_back({amps[c], 7'(c), bc_m});
        end
        bc_m = bc_m + 6'd1;
        beam_strobe = 1'b1;
        @(posedge clk); #1 beam_strobe = 1'b0;
        repeat (gap-1) @(posedge clk);
        #1;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 2000) begin
            @(posedge clk); t++;
        end
        repeat (40) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) amps[c] = '0;
        do_reset();
        // R1: reset state
        chk(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 32'h0);
        repeat (48) @(posedge clk); #1;
        chk(rx_n == 0, "R1 no hits after reset", 32'(rx_n), 32'h0);
        chk(idle_cnt > 0, "R8 idle frames seen", 32'(idle_cnt), 32'h1);

        // R2: strict threshold
        set_thr(3'd3);
        clear_amps();
        amps[0] = 3'd1; amps[5] = 3'd3; amps[6] = 3'd4; amps[7] = 3'd7;
        fire_beam(64);
        drain("R2 threshold hits delivered");

        // R3: mask, then unmask
        set_mask(7, 1'b1);
        clear_amps();
        amps[7] = 3'd7; amps[9] = 3'd6;
        fire_beam(64);
        drain("R3 masked channel suppressed");
        set_mask(7, 1'b0);
        fire_beam(64);
        drain("R3 unmasked channel restored");

        // R6 + R11: four hits in one beam clock, out-of-order strips
        set_thr(3'd0);
        clear_amps();
        amps[100] = 3'd2; amps[2] = 3'd5; amps[64] = 3'd1; amps[127] = 3'd7;
        fire_beam(16);
        drain("R6 ascending burst delivered");
        chk(overflow == 1'b0, "R11 no overflow on 4-hit burst", 32'(overflow), 32'h0);

        // R11: one hit per beam clock, tight spacing
        for (int k = 0; k < 4; k++) begin
            clear_amps();
            amps[10*k+3] = 3'(k+1);
            fire_beam(16);
        end
        drain("R11 sustained hits delivered");
        chk(overflow == 1'b0, "R11 no overflow sustained", 32'(overflow), 32'h0);

        // R5: beam counter wraps
        clear_amps();
        while (bc_m != 6'd62) fire_beam(16);
        amps[33] = 3'd3;
        fire_beam(16);
        fire_beam(16);
        fire_beam(16);
        drain("R5 counter wrap hits delivered");

        // R12: strobe while one hit is still unscanned
        do_reset();
        clear_amps();
        amps[1] = 3'd4; amps[2] = 3'd4; amps[3] = 3'd4;
        for (int c = 0; c < NCH; c++) amp_bus[c*3 +: 3] = amps[c];
        @(posedge clk); #1;
        beam_strobe = 1'b1;
        @(posedge clk); #1;
        beam_strobe = 1'b0;
        amp_bus = '0;
        exp_q.push_back({3'd4, 7'd1, 6'd0});
        exp_q.push_back({3'd4, 7'd2, 6'd0});
        @(posedge clk); #1;
        beam_strobe = 1'b1;
        @(posedge clk); #1;
        beam_strobe = 1'b0;
        @(posedge clk); #1;
        chk(overflow == 1'b1, "R12 overflow on discarded hit", 32'(overflow), 32'h1);
        drain("R12 only scanned hits delivered");
        chk(rx_n == 2, "R12 hit count", 32'(rx_n), 32'h2);

        // R10: burst larger than the queue
        do_reset();
        loose = 1'b1;
        clear_amps();
        for (int c = 10; c < 20; c++) amps[c] = 3'd5;
        for (int c = 0; c < NCH; c++) amp_bus[c*3 +: 3] = amps[c];
        beam_strobe = 1'b1;
        @(posedge clk); #1 beam_strobe = 1'b0;
        repeat (400) @(posedge clk); #1;
        chk(overflow == 1'b1, "R10 overflow set", 32'(overflow), 32'h1);
        chk(rx_log.size() >= 4 && rx_log.size() < 10, "R10 some hits dropped",
            32'(rx_log.size()), 32'h4);
        for (int k = 0; k < 4; k++) begin
            logic [15:0] e;
            e = {3'd5, 7'(10+k), 6'd0};
            chk(rx_log.size() > k && rx_log[k] == e, "R10 first queued hits kept",
                (rx_log.size() > k) ? 32'(rx_log[k]) : 32'hFFFF, 32'(e));
        end
        repeat (20) @(posedge clk); #1;
        chk(overflow == 1'b1, "R10 overflow sticky", 32'(overflow), 32'h1);
        loose = 1'b0;

        chk(idle_bad == 0, "R8 all idle words well formed", 32'(idle_bad), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule